// File: doc/BRIEF.md
# Keyed Watchdog and Reset Controller

This block is a small register-mapped watchdog that asks the chip for a reset when a countdown runs out. Software reaches it over a plain synchronous register bus: an address, a write strobe, 32 bits of write data and a combinational read-data return. Each write must carry a fixed key in its top byte. A write without that key is dropped without any sign. The lower 24 bits are the payload.

There are three registers. The control register holds a two-bit reset-configuration field at bits 5:4. The watchdog runs while bit 5 is set. The count register holds a 20-bit countdown that drops by one for every cycle in which the tick-enable input is high. One tick is 1/65536 s, so a timeout in seconds is that number shifted left by 16. The status register keeps a watchdog-cause flag and six boot-partition bits that software can write.

When the count runs out while the watchdog is running, the block raises its reset-request output for one cycle, returns the configuration field to the stopped code and sets the cause flag. Writing the count register while running reloads it at once, and this write is the keep-alive ping.

Top module: `keyed_wdog_ctrl`

## Requirements
- R1: A write whose data bits 31:24 are not 0x5A changes no register, whatever its address.
- R2: Every read returns zero in bits 31:24. A read of any address other than 0x1C, 0x20 or 0x24 returns zero.
- R3: A keyed write to 0x24 loads data bits 19:0 into the count. A read of 0x24 returns the remaining count in bits 19:0 and zero above.
- R4: The count drops by exactly one at each clock edge where tick-enable is high and control bit 5 is set. It holds otherwise.
- R5: A keyed write to 0x1C stores data bits 23:0 as the control value, which reads back unchanged. Bits 5:4 are the configuration field, and the code 0x20 starts the watchdog.
- R6: A keyed write of 0x102 to 0x1C stops the watchdog, so the count then stays frozen under ticks.
- R7: A tick while running with a count of 0 or 1 expires the watchdog. The reset request is high for the one cycle after that edge, the count becomes 0, control bits 5:4 clear, and the other control bits are kept.
- R8: With a count of 10 loaded and full reset selected, the reset request appears after exactly 10 ticks.
- R9: A keyed write to 0x20 replaces the boot-partition bits at positions 0, 2, 4, 6, 8 and 10 (mask 0x555) with the data. Other positions ignore the write, and 0x555 reads back as written.
- R10: Status bit 5 is set on every expiry and cleared by a keyed status write with data bit 5 high. If both happen in the same cycle, the set wins. Expiry leaves the partition bits alone.
- R11: A keyed count write in the same cycle as an expiring tick reloads the count with no decrement and no reset request.
- R12: A keyed control write in the same cycle as an expiry still produces the reset request, and the control register takes the written value.
- R13: After reset all three registers read zero and the reset request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data, key in bits 31:24 |
| busRdData | output | 32 | Read data for busAddr, combinational |
| tickEn | input | 1 | Countdown tick enable, one count per high cycle |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
The clash that matters is an expiring tick landing on the same edge as a bus write: a count reload, a control rewrite or a status clear. The bench sets up running with a count of one, then drives tick-enable high together with each of those writes. It judges the result from the reset-request pin and the read-back of all three registers in the cycles that follow. A behavioural model in the bench applies the stated priorities: a ping cancels the expiry, a control write wins the field but not the request, and a cause set beats a clear. A random phase mixes ticks with keyed and unkeyed writes so that these cases also occur unplanned.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int DATA_W    = 32;
  localparam int KEY_W     = 8;
  localparam int PAYLOAD_W = DATA_W - KEY_W;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_COUNT
  } regSel_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadCount;
    logic writeCtrl;
    logic writeStat;
    logic decrement;
    logic expire;
  } wdogStrobe_t;
endpackage

// File: rtl/keyed_wdog_ctl.sv
module keyed_wdog_ctl
  import keyed_wdog_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [KEY_W-1:0]  KEY      = 8'h5A,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h20,
  parameter logic [ADDR_W-1:0] CNT_OFS  = 'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [KEY_W-1:0]  busKey,
  input  logic              tickEn,
  input  logic              running,
  input  logic              countLow,
  output regSel_t           rdSel,
  output wdogStrobe_t       strb
);
  logic keyOk;
  logic tickLive;

  always_comb begin
    if (busAddr == CTRL_OFS)      rdSel = SEL_CTRL;
    else if (busAddr == STAT_OFS) rdSel = SEL_STAT;
    else if (busAddr == CNT_OFS)  rdSel = SEL_COUNT;
    else                          rdSel = SEL_NONE;
  end

  assign keyOk    = busWrEn && (busKey == KEY);
  assign tickLive = running && tickEn;

  always_comb begin
    strb           = '0;
    strb.loadCount = keyOk && (rdSel == SEL_COUNT);
    strb.writeCtrl = keyOk && (rdSel == SEL_CTRL);
    strb.writeStat = keyOk && (rdSel == SEL_STAT);
    // a ping in the same cycle cancels both the decrement and the expiry
    strb.expire    = tickLive && countLow && !strb.loadCount;
    strb.decrement = tickLive && !countLow && !strb.loadCount;
  end

  assert_key_gate_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busKey != KEY) |-> !(strb.loadCount || strb.writeCtrl || strb.writeStat));

  assert_ping_wins_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadCount |-> (!strb.expire && !strb.decrement));

  assert_tick_idle_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |-> (!strb.decrement && !strb.expire));
endmodule

// File: rtl/keyed_wdog_dp.sv
module keyed_wdog_dp
  import keyed_wdog_pkg::*;
#(
  parameter int                   CNT_W        = 20,
  parameter int                   CFG_LO       = 4,
  parameter logic [PAYLOAD_W-1:0] STAT_WR_MASK = 24'h555,
  parameter int                   CAUSE_BIT    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wdogStrobe_t          strb,
  input  regSel_t              rdSel,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 running,
  output logic                 countLow,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rstReq
);
  localparam int                   RUN_BIT  = CFG_LO + 1;
  localparam logic [PAYLOAD_W-1:0] CFG_MASK = PAYLOAD_W'(3) << CFG_LO;

  logic [PAYLOAD_W-1:0] ctrlQ;
  logic [PAYLOAD_W-1:0] statQ;
  logic [PAYLOAD_W-1:0] statNext;
  logic [CNT_W-1:0]     cntQ;
  logic                 reqQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctrlQ <= '0;
    else if (strb.writeCtrl) ctrlQ <= payload;
    else if (strb.expire)    ctrlQ <= ctrlQ & ~CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cntQ <= '0;
    else if (strb.loadCount) cntQ <= payload[CNT_W-1:0];
    else if (strb.expire)    cntQ <= '0;
    else if (strb.decrement) cntQ <= cntQ - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reqQ <= 1'b0;
    else        reqQ <= strb.expire;
  end

  // per-bit status behaviour chosen from the mask and the cause position
  for (genvar b = 0; b < PAYLOAD_W; b++) begin : g_stat
    if (STAT_WR_MASK[b]) begin : g_soft
      assign statNext[b] = strb.writeStat ? payload[b] : statQ[b];
    end else if (b == CAUSE_BIT) begin : g_cause
      assign statNext[b] = strb.expire ? 1'b1
                         : (strb.writeStat && payload[b]) ? 1'b0 : statQ[b];
    end else begin : g_fixed
      assign statNext[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statQ <= '0;
    else        statQ <= statNext;
  end

  assign running  = ctrlQ[RUN_BIT];
  assign countLow = (cntQ[CNT_W-1:1] == '0);
  assign rstReq   = reqQ;

  always_comb begin
    case (rdSel)
      SEL_CTRL:  rdData = {{KEY_W{1'b0}}, ctrlQ};
      SEL_STAT:  rdData = {{KEY_W{1'b0}}, statQ};
      SEL_COUNT: rdData = DATA_W'(cntQ);
      default:   rdData = '0;
    endcase
  end

  assert_count_dec_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    strb.decrement |=> (cntQ == $past(cntQ) - CNT_W'(1)));

  assert_count_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.loadCount && !strb.decrement && !strb.expire) |=> $stable(cntQ));

  assert_expire_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (strb.expire && !strb.writeCtrl) |=> (!running && rstReq && cntQ == '0));

  assert_expire_cause_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    strb.expire |=> statQ[CAUSE_BIT]);

  assert_stat_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.writeStat && !strb.expire) |=> $stable(statQ));
endmodule

// File: rtl/keyed_wdog_ctrl.sv
module keyed_wdog_ctrl
  import keyed_wdog_pkg::*;
#(
  parameter int                   ADDR_W       = 8,
  parameter int                   CNT_W        = 20,
  parameter logic [KEY_W-1:0]     KEY          = 8'h5A,
  parameter logic [ADDR_W-1:0]    CTRL_OFS     = 'h1C,
  parameter logic [ADDR_W-1:0]    STAT_OFS     = 'h20,
  parameter logic [ADDR_W-1:0]    CNT_OFS      = 'h24,
  parameter int                   CFG_LO       = 4,
  parameter logic [PAYLOAD_W-1:0] STAT_WR_MASK = 24'h555,
  parameter int                   CAUSE_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tickEn,
  output logic              rstReq
);
  regSel_t     rdSel;
  wdogStrobe_t strb;
  logic        running;
  logic        countLow;

  keyed_wdog_ctl #(
    .ADDR_W  (ADDR_W),
    .KEY     (KEY),
    .CTRL_OFS(CTRL_OFS),
    .STAT_OFS(STAT_OFS),
    .CNT_OFS (CNT_OFS)
  ) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busKey  (busWrData[DATA_W-1:PAYLOAD_W]),
    .tickEn  (tickEn),
    .running (running),
    .countLow(countLow),
    .rdSel   (rdSel),
    .strb    (strb)
  );

  keyed_wdog_dp #(
    .CNT_W       (CNT_W),
    .CFG_LO      (CFG_LO),
    .STAT_WR_MASK(STAT_WR_MASK),
    .CAUSE_BIT   (CAUSE_BIT)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .rdSel   (rdSel),
    .payload (busWrData[PAYLOAD_W-1:0]),
    .running (running),
    .countLow(countLow),
    .rdData  (busRdData),
    .rstReq  (rstReq)
  );
endmodule

// File: tb/keyed_wdog_ctrl_test.sv
`timescale 1ns/1ps
module keyed_wdog_ctrl_test;
  localparam logic [7:0] A_CTRL = 8'h1C;
  localparam logic [7:0] A_STAT = 8'h20;
  localparam logic [7:0] A_CNT  = 8'h24;

  logic        clk;
  logic        rst_n;
  logic [7:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        tickEn;
  logic        rstReq;

  int    checks;
  int    fails;
  bit    chkOn;
  string curReq;

  logic [23:0] mCtrl;
  logic [23:0] mStat;
  logic [19:0] mCnt;
  logic        mReq;

  keyed_wdog_ctrl uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tickEn(tickEn), .rstReq(rstReq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference, updated from the inputs seen at each edge
  always @(posedge clk) begin : refModel
    logic keyOk, wCtrl, wStat, wCnt, runNow, expNow;
    if (!rst_n) begin
      mCtrl = '0; mStat = '0; mCnt = '0; mReq = 1'b0;
    end else begin
      keyOk  = busWrEn && (busWrData[31:24] == 8'h5A);
      wCtrl  = keyOk && busAddr == A_CTRL;
      wStat  = keyOk && busAddr == A_STAT;
      wCnt   = keyOk && busAddr == A_CNT;
      runNow = mCtrl[5];
      expNow = runNow && tickEn && (mCnt <= 1) && !wCnt;
      mReq   = expNow;
      if (wCnt) mCnt = busWrData[19:0];
      else if (expNow) mCnt = '0;
      else if (runNow && tickEn) mCnt = mCnt - 1;
      if (wCtrl) mCtrl = busWrData[23:0];
      else if (expNow) mCtrl = mCtrl & ~24'h30;
      if (wStat) begin
        mStat = (mStat & ~24'h555) | (busWrData[23:0] & 24'h555);
        if (busWrData[5]) mStat[5] = 1'b0;
      end
      if (expNow) mStat[5] = 1'b1;
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      A_CTRL:  return {8'h00, mCtrl};
      A_STAT:  return {8'h00, mStat};
      A_CNT:   return {12'h000, mCnt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      check(curReq, "rstReq", {31'b0, rstReq}, {31'b0, mReq});
      check(curReq, "read", busRdData, expRead(busAddr));
    end
  end

  task automatic drive(input logic [7:0] a, input logic we,
                       input logic [31:0] d, input logic tk);
    @(posedge clk);
    #1;
    busAddr = a; busWrEn = we; busWrData = d; tickEn = tk;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    bit seen;
    rst_n = 1'b0; busAddr = A_CNT; busWrEn = 1'b0; busWrData = '0; tickEn = 1'b0;
    checks = 0; fails = 0; chkOn = 1'b0;
    curReq = "R13";
    @(posedge clk);
    chkOn = 1'b1;
    drive(A_CTRL, 1, 32'h5A000020, 1);
    drive(A_STAT, 0, 0, 1);
    drive(A_CNT, 0, 0, 1);
    rst_n = 1'b1;
    drive(A_CTRL, 0, 0, 0);
    drive(A_STAT, 0, 0, 0);

    curReq = "R2";
    drive(8'h00, 0, 0, 0);
    drive(8'h28, 0, 0, 0);
    drive(8'h1D, 0, 0, 0);
    drive(8'hFC, 0, 0, 0);

    curReq = "R3";
    drive(A_CNT, 1, 32'h5A0ABCDE, 0);
    drive(A_CNT, 0, 0, 0);
    drive(A_CNT, 1, 32'h5AFFFFFF, 0);
    drive(A_CNT, 0, 0, 1);
    drive(A_CNT, 0, 0, 1);
    drive(A_CNT, 0, 0, 0);

    curReq = "R1";
    drive(A_CTRL, 1, 32'hA5000020, 1);
    drive(A_CNT, 1, 32'h00012345, 1);
    drive(A_STAT, 1, 32'h12000555, 0);
    drive(8'h28, 1, 32'h5A000020, 1);
    drive(A_CTRL, 0, 0, 1);
    drive(A_STAT, 0, 0, 1);
    drive(A_CNT, 0, 0, 1);

    curReq = "R5";
    drive(A_CNT, 1, 32'h5A000014, 0);
    drive(A_CTRL, 1, 32'h5A000020, 0);
    drive(A_CTRL, 0, 0, 0);
    curReq = "R4";
    for (int k = 0; k < 12; k++) drive(A_CNT, 0, 0, (k % 3) != 0);

    curReq = "R6";
    drive(A_CTRL, 1, 32'h5A000102, 0);
    for (int k = 0; k < 4; k++) drive(A_CNT, 0, 0, 1);
    drive(A_CTRL, 0, 0, 0);

    curReq = "R8";
    drive(A_CNT, 1, 32'h5A00000A, 0);
    drive(A_CTRL, 1, 32'h5A000321, 0);
    drive(A_CNT, 0, 0, 1);
    n = 0; seen = 1'b0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rstReq) seen = 1'b1;
    end
    check("R8", "ticks to reset", n, 10);
    curReq = "R7";
    drive(A_CTRL, 0, 0, 0);
    drive(A_CNT, 0, 0, 1);
    curReq = "R10";
    drive(A_STAT, 0, 0, 0);

    curReq = "R9";
    drive(A_STAT, 1, 32'h5AFFFFFF, 0);
    drive(A_STAT, 0, 0, 0);
    drive(A_STAT, 1, 32'h5A000041, 0);
    drive(A_STAT, 1, 32'h5A000555, 0);
    drive(A_STAT, 0, 0, 0);

    curReq = "R10";
    drive(A_CNT, 1, 32'h5A000002, 0);
    drive(A_CTRL, 1, 32'h5A000020, 0);
    for (int k = 0; k < 3; k++) drive(A_STAT, 0, 0, 1);
    drive(A_STAT, 1, 32'h5A000575, 0);
    drive(A_CNT, 1, 32'h5A000001, 0);
    drive(A_CTRL, 1, 32'h5A000020, 0);
    drive(A_STAT, 1, 32'h5A000020, 1);
    drive(A_STAT, 0, 0, 0);

    curReq = "R11";
    drive(A_CNT, 1, 32'h5A000001, 0);
    drive(A_CTRL, 1, 32'h5A000020, 0);
    drive(A_CNT, 1, 32'h5A000032, 1);
    drive(A_CNT, 0, 0, 0);
    drive(A_CNT, 0, 0, 1);
    drive(A_CNT, 0, 0, 1);

    curReq = "R12";
    drive(A_CNT, 1, 32'h5A000001, 0);
    drive(A_CTRL, 1, 32'h5A000030, 1);
    drive(A_CTRL, 0, 0, 0);
    curReq = "R7";
    drive(A_CNT, 0, 0, 1);
    drive(A_CTRL, 0, 0, 0);
    drive(A_STAT, 0, 0, 0);

    curReq = "R4";
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      logic [7:0]  a;
      logic [31:0] d;
      r = $urandom;
      case (r[1:0])
        2'd0: a = A_CTRL;
        2'd1: a = A_STAT;
        2'd2: a = A_CNT;
        default: a = 8'h30;
      endcase
      d[31:24] = r[4] ? 8'h5A : r[31:24];
      case (a)
        A_CTRL:  d[23:0] = r[6] ? 24'h000020 : (r[7] ? 24'h000102 : 24'h000030);
        A_CNT:   d[23:0] = {21'b0, r[10:8]};
        default: d[23:0] = {12'b0, r[23:12]};
      endcase
      drive(a, r[3:2] == 2'b00, d, r[5] | r[11]);
    end

    drive(A_CNT, 0, 0, 0);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule